// File: doc/BRIEF.md
# Escalating Recovery Watchdog

This block supervises a single processing unit through a periodic service pulse (the kick). The unit may let the kick lapse for a full timeout window. The block then drives a recovery reset pulse of fixed length into the unit, waits for the pulse to finish, and starts timing again. Each recovery reset adds one to a counter of consecutive resets. When the unit runs for a full timeout window after a recovery without timing out, the counter returns to zero.

If the unit times out again after it has already received the configured number of consecutive recovery resets, the fault counts as one that a reset cannot cure. The block then pulls its active-low soft-error line low and holds it there. While that line is low, no further recovery resets are issued and kicks are ignored. The line stays low until a fault-clear strobe or a system reset arrives. The soft-error line is meant to feed the logic that decides on a failover to a spare unit.

The timeout length, the pulse length and the retry limit are parameters.

Top module: `esc_wd_supervisor`

## Requirements
- R1: After the asynchronous active-low system reset, `unit_rst_o` is 0, `soft_err_n_o` is 1 and `rst_count_o` is 0.
- R2: While the block is running, a kick in any cycle restarts the timeout window. A unit that kicks at least once every TIMEOUT_CYC cycles never receives a recovery reset.
- R3: If TIMEOUT_CYC consecutive clock edges in the running state see no kick, `unit_rst_o` rises after the last of those edges.
- R4: `unit_rst_o` stays high for exactly PULSE_LEN cycles. Kicks during the pulse are ignored, and the timeout window starts from zero when the pulse ends.
- R5: Each recovery reset increments `rst_count_o` by one, in the same cycle that `unit_rst_o` rises. `rst_count_o` never exceeds RETRY_LIMIT.
- R6: After a recovery pulse ends, if TIMEOUT_CYC cycles of running pass with no timeout, `rst_count_o` returns to 0.
- R7: A timeout while `rst_count_o` equals RETRY_LIMIT drives `soft_err_n_o` to 0 and issues no pulse. `rst_count_o` stays at RETRY_LIMIT. The value 0 means soft fault and 1 means normal.
- R8: While `soft_err_n_o` is 0, it stays 0, `unit_rst_o` stays 0 and kicks have no effect, until a fault-clear or system reset occurs.
- R9: A `fault_clr_i` strobe while `soft_err_n_o` is 0 sets it to 1 and `rst_count_o` to 0, and timing restarts from zero. A strobe at any other time has no effect.
- R10: A system reset applied at any point, including the latched state, returns all outputs to their R1 values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| kick_i | input | 1 | Service pulse from the supervised unit |
| fault_clr_i | input | 1 | Strobe that releases a latched soft fault |
| unit_rst_o | output | 1 | Recovery reset pulse to the unit, active high |
| soft_err_n_o | output | 1 | Soft-error line, 0 when the fault is latched |
| rst_count_o | output | CNT_W | Consecutive recovery resets issued |

## Verification
The assertions assume that `kick_i` and `fault_clr_i` are synchronous to `clk` and settle well away from its rising edge. They also assume that the parameters keep TIMEOUT_CYC, PULSE_LEN and RETRY_LIMIT at 1 or more. The stimulus changes both inputs only on falling clock edges. It uses kick spacings both below and above the timeout window, kicks during pulses and during the latched state, and clear strobes both inside and outside the latched state. A behavioural model, kept in integers, predicts every output on every cycle.

// File: rtl/esc_wd_pkg.sv
package esc_wd_pkg;
    // Bits needed to hold values 0..n inclusive.
    function automatic int unsigned bits_for(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/esc_wd_timer.sv
module esc_wd_timer
    import esc_wd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic kick_i,
    output logic expire_o
);
    localparam int unsigned TW = bits_for(TIMEOUT_CYC);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d    = tmr_q;
        expire_o = run_i && !kick_i && (tmr_q.cnt == TW'(TIMEOUT_CYC - 1));
        if (!run_i || kick_i || expire_o) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R2: the idle count never passes the window
    a_r2_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= TW'(TIMEOUT_CYC - 1));
    // R4: the window is held at zero while not running
    a_r4_timer_held: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> tmr_q.cnt == '0);
endmodule

// File: rtl/esc_wd_pulse.sv
module esc_wd_pulse
    import esc_wd_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned PW = bits_for(PULSE_LEN);

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] cnt;
    } pls_t;

    pls_t pls_d, pls_q;

    always_comb begin
        pls_d = pls_q;
        if (pls_q.busy) begin
            if (pls_q.cnt == PW'(PULSE_LEN - 1)) begin
                pls_d.busy = 1'b0;
                pls_d.cnt  = '0;
            end else begin
                pls_d.cnt = pls_q.cnt + 1'b1;
            end
        end else if (start_i) begin
            pls_d.busy = 1'b1;
            pls_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pls_q <= '0;
        else        pls_q <= pls_d;
    end

    assign busy_o = pls_q.busy;

    // R4: the pulse is not cut short
    a_r4_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pls_q.busy && (pls_q.cnt != PW'(PULSE_LEN - 1)) |=> pls_q.busy);
    // R4: the pulse ends only after its full length
    a_r4_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pls_q.busy) |-> $past(pls_q.cnt) == PW'(PULSE_LEN - 1));
    // R4: no new request arrives while a pulse is running
    a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !pls_q.busy);
endmodule

// File: rtl/esc_wd_ladder.sv
module esc_wd_ladder
    import esc_wd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 16,
    parameter int unsigned RETRY_LIMIT = 3,
    localparam int unsigned CNT_W = bits_for(RETRY_LIMIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expire_i,
    input  logic             run_i,
    input  logic             clear_i,
    output logic             fire_o,
    output logic             latched_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int unsigned HW = bits_for(TIMEOUT_CYC);

    typedef struct packed {
        logic             latched;
        logic [CNT_W-1:0] count;
        logic [HW-1:0]    health;
    } lad_t;

    lad_t lad_d, lad_q;
    logic at_limit;

    always_comb begin
        lad_d    = lad_q;
        at_limit = (lad_q.count == CNT_W'(RETRY_LIMIT));
        fire_o   = expire_i && !at_limit && !lad_q.latched;
        if (lad_q.latched) begin
            lad_d.health = '0;
            if (clear_i) begin
                lad_d.latched = 1'b0;
                lad_d.count   = '0;
            end
        end else if (expire_i) begin
            lad_d.health = '0;
            if (at_limit) lad_d.latched = 1'b1;
            else          lad_d.count   = lad_q.count + 1'b1;
        end else if (run_i) begin
            if (lad_q.health == HW'(TIMEOUT_CYC - 1)) begin
                lad_d.count = '0;
            end else begin
                lad_d.health = lad_q.health + 1'b1;
            end
        end else begin
            lad_d.health = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lad_q <= '0;
        else        lad_q <= lad_d;
    end

    assign latched_o = lad_q.latched;
    assign count_o   = lad_q.count;

    // R5: the counter stays within the limit
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        lad_q.count <= CNT_W'(RETRY_LIMIT));
    // R7: the latch sets only from a timeout at the limit
    a_r7_latch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_q.latched) |-> $past(expire_i) && lad_q.count == CNT_W'(RETRY_LIMIT));
    // R8: the latch holds until a clear
    a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        lad_q.latched && !clear_i |=> lad_q.latched);
    // R8: no timeout is reported while latched
    a_r8_no_expire_latched: assert property (@(posedge clk) disable iff (!rst_n)
        lad_q.latched |-> !expire_i);
endmodule

// File: rtl/esc_wd_supervisor.sv
module esc_wd_supervisor
    import esc_wd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 16,
    parameter int unsigned PULSE_LEN   = 4,
    parameter int unsigned RETRY_LIMIT = 3,
    localparam int unsigned CNT_W = bits_for(RETRY_LIMIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             kick_i,
    input  logic             fault_clr_i,
    output logic             unit_rst_o,
    output logic             soft_err_n_o,
    output logic [CNT_W-1:0] rst_count_o
);
    logic run, expire, fire, busy, latched;

    assign run = !busy && !latched;

    esc_wd_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .run_i(run), .kick_i(kick_i), .expire_o(expire)
    );

    esc_wd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start_i(fire), .busy_o(busy)
    );

    esc_wd_ladder #(.TIMEOUT_CYC(TIMEOUT_CYC), .RETRY_LIMIT(RETRY_LIMIT)) u_ladder (
        .clk(clk), .rst_n(rst_n), .expire_i(expire), .run_i(run), .clear_i(fault_clr_i),
        .fire_o(fire), .latched_o(latched), .count_o(rst_count_o)
    );

    assign unit_rst_o   = busy;
    assign soft_err_n_o = !latched;

    // R8: no recovery pulse while the soft fault is latched
    a_r8_no_pulse_latched: assert property (@(posedge clk) disable iff (!rst_n)
        !soft_err_n_o |-> !unit_rst_o);
    // R5: each new pulse comes with a count step of one
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unit_rst_o) |-> rst_count_o == $past(rst_count_o) + 1'b1);
endmodule

// File: tb/tb_esc_wd_supervisor.sv
module tb_esc_wd_supervisor;
    localparam int T   = 16;
    localparam int L   = 4;
    localparam int LIM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick = 1'b0;
    logic clr = 1'b0;
    logic unit_rst, soft_err_n;
    logic [1:0] rcount;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    esc_wd_supervisor #(.TIMEOUT_CYC(T), .PULSE_LEN(L), .RETRY_LIMIT(LIM)) dut (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .fault_clr_i(clr),
        .unit_rst_o(unit_rst), .soft_err_n_o(soft_err_n), .rst_count_o(rcount)
    );

    // Behavioural reference model
    int idle = 0, pulse_left = 0, fails = 0, good = 0;
    bit latched = 1'b0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle = 0; pulse_left = 0; fails = 0; good = 0; latched = 1'b0;
        end else if (latched) begin
            if (clr) begin latched = 1'b0; fails = 0; end
            idle = 0; good = 0;
        end else if (pulse_left > 0) begin
            pulse_left--; idle = 0; good = 0;
        end else if (!kick && idle == T - 1) begin
            if (fails == LIM) latched = 1'b1;
            else begin fails++; pulse_left = L; end
            idle = 0; good = 0;
        end else begin
            idle = kick ? 0 : idle + 1;
            if (good == T - 1) fails = 0;
            else good++;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Lockstep comparison away from the active edge
    int rises = 0;
    logic prev_rst = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4 unit_rst", int'(unit_rst), int'(pulse_left > 0));
            chk("R5 count", int'(rcount), fails);
            chk("R7 soft_err_n", int'(soft_err_n), int'(!latched));
            if (unit_rst && !prev_rst) rises++;
        end
        prev_rst = unit_rst;
    end

    task automatic quiet(int n);
        kick = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic kick_every(int n, int period);
        for (int i = 0; i < n; i++) begin
            kick = (i % period) == 0;
            @(negedge clk);
        end
        kick = 1'b0;
    endtask

    task automatic strobe_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        int r0;
        repeat (3) @(negedge clk);
        chk("R1 unit_rst", int'(unit_rst), 0);
        chk("R1 soft_err_n", int'(soft_err_n), 1);
        chk("R1 count", int'(rcount), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: regular kicks below the window
        r0 = rises;
        kick_every(120, 10);
        kick_every(60, T);
        chk("R2 no pulse", rises - r0, 0);

        // R3: exact timeout cycle
        kick = 1'b1; @(negedge clk); kick = 1'b0;
        repeat (T - 1) begin
            @(negedge clk);
            chk("R3 before timeout", int'(unit_rst), 0);
        end
        @(negedge clk);
        chk("R3 at timeout", int'(unit_rst), 1);

        // R4: kicks during the pulse ignored
        kick_every(L, 1);
        chk("R4 pulse over", int'(unit_rst), 0);
        chk("R5 one reset", int'(rcount), 1);

        // R9: clear outside latch has no effect
        strobe_clr();
        chk("R9 clear ignored", int'(rcount), 1);

        // R6: healthy window clears the count
        kick_every(3 * T, 5);
        chk("R6 count cleared", int'(rcount), 0);

        // R7: escalate to latched soft error
        quiet((LIM + 1) * (T + L) + 4);
        chk("R7 soft_err_n low", int'(soft_err_n), 0);
        chk("R7 count at limit", int'(rcount), LIM);

        // R8: latched holds, kicks ignored
        r0 = rises;
        kick_every(80, 3);
        quiet(40);
        chk("R8 no pulses", rises - r0, 0);
        chk("R8 still latched", int'(soft_err_n), 0);

        // R9: clear releases and timing restarts
        strobe_clr();
        chk("R9 released", int'(soft_err_n), 1);
        chk("R9 count zero", int'(rcount), 0);
        quiet(T + 1);
        chk("R9 new timeout", int'(unit_rst), 1);

        // R10: reset from latched state
        quiet((LIM + 1) * (T + L) + 4);
        chk("R10 latched before reset", int'(soft_err_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 soft_err_n", int'(soft_err_n), 1);
        chk("R10 count", int'(rcount), 0);
        chk("R10 unit_rst", int'(unit_rst), 0);
        rst_n = 1'b1;
        kick_every(50, 7);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule